// File: doc/BRIEF.md
# Chirp K-J Sequence Validator

This block watches the two-bit line-state output of a USB 2.0 transceiver during high-speed negotiation and decides whether the upstream port answered with a proper chirp train. The line state is not filtered, so each bus level is deglitched by sampling it on every clock. A level becomes *qualified* only after it has been seen unchanged for a programmable number of consecutive samples. At 60 MHz, 150 samples cover 2.5 us.

After a start pulse, a small sequencer expects a qualified K, then a qualified J, and so on in alternation. Each accepted level advances a chirp counter. When the counter reaches the target, which is six by default, a one-cycle valid pulse is issued. A qualified SE0 seen before that point produces a one-cycle invalid pulse instead. After either outcome the sequencer goes idle and ignores the bus until it is started again. The current count is always visible on a port.

Top module: `chirp_seq_checker`

## Requirements
- R1: A start pulse clears the chirp count to 0 and makes the sequencer wait for a K. A qualified J present at that time is not counted.
- R2: A bus level is qualified only after QUAL_CYCLES consecutive identical samples, and a run of exactly QUAL_CYCLES samples is enough. A shorter run of any level has no effect, including SE0, and any change of level restarts the run.
- R3: While waiting for K, a qualified K raises the count by one and the sequencer then waits for J.
- R4: While waiting for J, a qualified J raises the count by one and the sequencer then waits for K.
- R5: When the count reaches CHIRP_TARGET (6), chirp_valid is high for exactly one cycle while chirp_count already shows 6. The sequencer then goes idle, and the count holds.
- R6: A qualified SE0 while the count is below the target drives chirp_invalid high for exactly one cycle. The sequencer then goes idle, and the count holds at its value.
- R7: The line-state encoding is 00 for SE0, 01 for J and 10 for K. The code 11 matches none of them and never changes the count or produces a pulse.
- R8: A single long qualified level is counted once. The opposite level must be qualified before the count can advance again.
- R9: While idle, bus activity changes neither the count nor the pulse outputs. A start pulse received in the middle of a sequence restarts it from 0.
- R10: After reset, the count is 0, both pulses are low and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a new chirp check |
| line_state | input | 2 | Raw transceiver line state (00 SE0, 01 J, 10 K, 11 unused) |
| chirp_valid | output | 1 | One-cycle pulse: six alternating levels seen |
| chirp_invalid | output | 1 | One-cycle pulse: SE0 seen before the target |
| chirp_count | output | $clog2(CHIRP_TARGET+1) | Number of levels accepted in the current check |

## Verification
The main function is tested with several kinds of input:
- A clean K/J train, which shows that the sequence completes and alternation is enforced.
- A train that starts with J and contains one very long J, which separates level-based counting from edge-based counting.
- Level runs one sample short of the qualification time and exactly at it, including a short SE0, which pin down the filter boundary.
- SE0 at count 0 and mid-train, which tells abort apart from completion.
- The unused code 11, idle-time activity and a restart in the middle of a train, which confirm these inputs are ignored or reset the check as specified.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_BAD = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WANT_K = 2'd1,
    ST_WANT_J = 2'd2
  } seq_e;

endpackage

// File: rtl/chirp_line_filter.sv
module chirp_line_filter
  import chirp_pkg::*;
#(
  parameter int QUAL_CYCLES = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_i,
  output logic       q_valid_o,
  output line_e      q_state_o
);

  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] RUN_MAX = QW'(QUAL_CYCLES);

  line_e         last_q;
  logic [QW-1:0] run_q;
  line_e         line_now;

  assign line_now = line_e'(line_i);

  // Run length of the current sampled level, saturating at the threshold.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= LS_BAD;
      run_q  <= '0;
    end else begin
      last_q <= line_now;
      if (line_now != last_q) begin
        run_q <= QW'(1);
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + QW'(1);
      end
    end
  end

  assign q_valid_o = (run_q == RUN_MAX);
  assign q_state_o = last_q;

  // A level change must drop qualification on the next cycle.
  if (QUAL_CYCLES > 1) begin : g_chg_chk
    p_change_unqualifies_r2: assert property (@(posedge clk) disable iff (rst)
      (line_now != last_q) |=> !q_valid_o);
  end

  // Qualification can only begin while the level is unchanged.
  p_rise_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(q_valid_o) |-> $stable(q_state_o));

endmodule

// File: rtl/chirp_seq_fsm.sv
module chirp_seq_fsm
  import chirp_pkg::*;
#(
  parameter int CHIRP_TARGET = 6
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start_i,
  input  logic                                q_valid_i,
  input  line_e                               q_state_i,
  output logic                                valid_o,
  output logic                                invalid_o,
  output logic [$clog2(CHIRP_TARGET+1)-1:0]   count_o
);

  localparam int CW = $clog2(CHIRP_TARGET + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(CHIRP_TARGET - 1);
  localparam logic [CW-1:0] TARGET    = CW'(CHIRP_TARGET);

  seq_e          state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          valid_q, valid_n;
  logic          invalid_q, invalid_n;
  logic          want_hit;
  line_e         want_lvl;

  assign want_lvl = (state_q == ST_WANT_K) ? LS_K : LS_J;
  assign want_hit = q_valid_i && (q_state_i == want_lvl);

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    valid_n   = 1'b0;
    invalid_n = 1'b0;
    if (start_i) begin
      state_n = ST_WANT_K;
      cnt_n   = '0;
    end else if (state_q != ST_IDLE) begin
      if (q_valid_i && (q_state_i == LS_SE0)) begin
        invalid_n = 1'b1;
        state_n   = ST_IDLE;
      end else if (want_hit) begin
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == LAST_STEP) begin
          valid_n = 1'b1;
          state_n = ST_IDLE;
        end else begin
          state_n = (state_q == ST_WANT_K) ? ST_WANT_J : ST_WANT_K;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      valid_q   <= 1'b0;
      invalid_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      valid_q   <= valid_n;
      invalid_q <= invalid_n;
    end
  end

  assign valid_o   = valid_q;
  assign invalid_o = invalid_q;
  assign count_o   = cnt_q;

  p_valid_at_target_r5: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (cnt_q == TARGET));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  p_invalid_single_r6: assert property (@(posedge clk) disable iff (rst)
    invalid_q |=> !invalid_q);

  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(valid_q && invalid_q));

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1))));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start_i) |=> ($stable(cnt_q) && !valid_q && !invalid_q));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TARGET);

endmodule

// File: rtl/chirp_seq_checker.sv
module chirp_seq_checker
  import chirp_pkg::*;
#(
  parameter int QUAL_CYCLES  = 150,
  parameter int CHIRP_TARGET = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [1:0]                        line_state,
  output logic                              chirp_valid,
  output logic                              chirp_invalid,
  output logic [$clog2(CHIRP_TARGET+1)-1:0] chirp_count
);

  logic  qual_valid;
  line_e qual_state;

  chirp_line_filter #(
    .QUAL_CYCLES(QUAL_CYCLES)
  ) u_filter (
    .clk      (clk),
    .rst      (rst),
    .line_i   (line_state),
    .q_valid_o(qual_valid),
    .q_state_o(qual_state)
  );

  chirp_seq_fsm #(
    .CHIRP_TARGET(CHIRP_TARGET)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .q_valid_i(qual_valid),
    .q_state_i(qual_state),
    .valid_o  (chirp_valid),
    .invalid_o(chirp_invalid),
    .count_o  (chirp_count)
  );

endmodule

// File: tb/test_chirp_seq_checker.sv
module test_chirp_seq_checker;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int QUAL = 150;
  localparam int TGT  = 6;
  localparam logic [1:0] SE0 = 2'b00, JJ = 2'b01, KK = 2'b10, XX = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] line = JJ;
  logic       valid, invalid;
  logic [2:0] count;

  typedef struct {bit is_valid; int cnt; string req;} exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chirp_seq_checker #(.QUAL_CYCLES(QUAL), .CHIRP_TARGET(TGT)) i_chirp_seq_checker (
    .clk(clk), .rst(rst), .start(start), .line_state(line),
    .chirp_valid(valid), .chirp_invalid(invalid), .chirp_count(count));

  task automatic check_int(string req, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic hold(logic [1:0] st, int n);
    for (int i = 0; i < n; i++) begin
      line = st;
      @(negedge clk);
    end
  endtask

  task automatic seg(logic [1:0] st);
    hold(st, QUAL + 2);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_evt(bit v, int c, string r);
    exp_t e;
    e.is_valid = v; e.cnt = c; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: every pulse must match the next expected outcome.
  always @(negedge clk) begin
    if (!rst && (valid || invalid)) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected pulse actual=v%0d/i%0d count=%0d expected=none",
                 valid, invalid, count);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (valid !== e.is_valid || invalid !== !e.is_valid || int'(count) != e.cnt) begin
          n_bad++;
          $display("FAIL %s pulse actual=v%0d/i%0d count=%0d expected=v%0d/i%0d count=%0d",
                   e.req, valid, invalid, count, e.is_valid, !e.is_valid, e.cnt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_int("R10", "count after reset", count, 0);
    check_int("R10", "valid after reset", valid, 0);
    check_int("R10", "invalid after reset", invalid, 0);
    hold(KK, QUAL + 5);
    check_int("R10", "idle ignores K", count, 0);

    // Clean train, with a leading J and one very long J.
    seg(JJ);
    pulse_start();
    check_int("R1", "count after start", count, 0);
    seg(JJ);
    check_int("R1", "J first not counted", count, 0);
    seg(KK);
    check_int("R3", "K counted", count, 1);
    seg(JJ);
    check_int("R4", "J counted", count, 2);
    hold(JJ, 3 * QUAL);
    check_int("R8", "long J counted once", count, 2);
    seg(KK);
    check_int("R3", "second K", count, 3);
    seg(JJ);
    check_int("R4", "second J", count, 4);
    seg(KK);
    check_int("R3", "third K", count, 5);
    expect_evt(1'b1, 6, "R5");
    seg(JJ);
    check_int("R5", "count holds at target", count, 6);
    seg(KK);
    seg(SE0);
    check_int("R9", "idle after valid", count, 6);

    // Filter boundaries.
    seg(JJ);
    pulse_start();
    hold(KK, QUAL - 1);
    hold(JJ, QUAL + 2);
    check_int("R2", "K one sample short", count, 0);
    hold(KK, QUAL);
    hold(XX, QUAL + 2);
    check_int("R2", "K exactly at threshold", count, 1);
    check_int("R7", "code 11 ignored", count, 1);
    hold(SE0, QUAL - 1);
    hold(JJ, QUAL + 2);
    check_int("R2", "short SE0 ignored", count, 2);

    // Restart in mid-train, then abort with SE0.
    pulse_start();
    check_int("R9", "restart clears", count, 0);
    seg(KK);
    check_int("R3", "K after restart", count, 1);
    expect_evt(1'b0, 1, "R6");
    seg(SE0);
    check_int("R6", "count held after abort", count, 1);
    seg(JJ);
    seg(KK);
    check_int("R9", "idle after invalid", count, 1);

    // Abort at zero.
    seg(JJ);
    pulse_start();
    expect_evt(1'b0, 0, "R6");
    seg(SE0);
    check_int("R6", "abort at zero", count, 0);

    // Code 11 while waiting for K.
    seg(JJ);
    pulse_start();
    seg(XX);
    check_int("R7", "11 in K wait", count, 0);
    seg(KK);
    check_int("R7", "K after 11", count, 1);

    hold(JJ, 4);
    check_int("R5", "outstanding expected pulses", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule